// File: doc/BRIEF.md
# Prioritized Address Bus Arbiter

This block decides who drives a shared processor address bus. The competing masters are a set of processor request lines, one external secondary-cache controller, and one internal requester. The internal requester stands for snoop broadcasts and for pushes or cast-outs from an on-chip cache. Each request carries a three-bit transaction class, and the class with the highest rank wins. Ties are broken in a fixed order. Among processors, ties rotate. A processor doing an L1 copy-back outranks every other class, so it also beats the rotation.

Each address tenure takes three cycles. The grant is high for one cycle. The address acknowledge follows in the next cycle. A retry window comes after that. A count of address tenures whose data has not finished provides one level of pipelining. No new grant is issued while two such tenures are pending. A processor tenure retried in its window is remembered. Once the internal requester finishes a snoop-class tenure, the next grant goes back to that processor. When parking is enabled and nobody requests, the grant rests on the processor that owned the bus last.

Top module: `addr_bus_arbiter`

## Requirements
- R1: While rst_ni is low, every grant and aack_o are 0, the pending-tenure count is 0, the rotation pointer is processor 0 and the parking target is processor 0.
- R2: Class codes and their rank, highest first: 5 L1 copy-back, 4 external L2 snoop push, 3 internal push or cast-out, 2 snoop, 1 external L2 cast-out, 0 plain request. The reserved codes 6 and 7 rank as 0. The requester with the highest rank wins the grant.
- R3: Among requesters of equal rank, the internal requester wins first, then the external L2 controller, then the processors. When int_gnt_o is high, no other grant is high.
- R4: Among processors of equal rank, the search starts at the rotation pointer and goes upward, wrapping around. After a real grant to processor k, the pointer becomes k+1, wrapping to 0 after NUM_CPU-1.
- R5: A processor requesting with class 5 wins over every other requester that is not at class 5, whatever the rotation pointer says.
- R6: Decisions happen only at clock edges that leave an idle cycle or a retry-window cycle. A real grant is high for one cycle. aack_o is high in the next cycle, and all grants are low in that cycle and in the retry-window cycle after it. At most one grant is high at any time.
- R7: The pending count goes up by one for each real grant. It goes down by one for data_done_i and by one for artry_i sampled in a retry-window cycle, and it never goes below 0. No real grant is made at an edge where the count, as it stood before that edge, equals MAX_PEND (2 by default).
- R8: artry_i high in the retry window of a processor tenure records that processor. When a later internal tenure of class 2 is acknowledged, a grant-back becomes armed. At the next decision, if that processor requests, it gets the grant ahead of every other requester. Any real grant disarms the grant-back.
- R9: At a decision edge where no request is present and park_en_i is 1, the grant of the most recent processor master is set. This parked grant is not followed by aack_o and does not change the pending count.
- R10: At a decision edge where no request is present and park_en_i is 0, all grants are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| park_en_i | input | 1 | Enables parking on the last processor master |
| cpu_req_i | input | NUM_CPU | Processor address bus requests |
| cpu_cls_i | input | 3*NUM_CPU | Class code per processor; processor k uses bits [3k+2:3k] |
| l2_req_i | input | 1 | External secondary-cache controller request |
| l2_cls_i | input | 3 | Class code of the L2 request |
| int_req_i | input | 1 | Internal snoop/cast-out request |
| int_cls_i | input | 3 | Class code of the internal request |
| artry_i | input | 1 | Address retry, used only in the retry-window cycle |
| data_done_i | input | 1 | One outstanding data tenure has finished |
| cpu_gnt_o | output | NUM_CPU | Processor address bus grants |
| l2_gnt_o | output | 1 | L2 controller grant |
| int_gnt_o | output | 1 | Internal requester grant |
| aack_o | output | 1 | Address acknowledge to the current master |

## Verification
The interesting collision is the retry-window edge. At that one edge the arbiter uses artry_i to withdraw a pending tenure and record a grant-back owner, and it also picks the next master using the count as it stood before that withdrawal. data_done_i can land on the same edge as well. The bench provokes this with a directed retry of a processor, followed by an internal snoop tenure while other processors keep requesting. A random phase then drives artry_i and data_done_i freely. The outputs are judged each cycle against a behavioural model that applies the same edge ordering: the count used for a decision is the value from before that edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN     = 3'd0,
    CLS_L2_CAST   = 3'd1,
    CLS_SNOOP     = 3'd2,
    CLS_INT_PUSH  = 3'd3,
    CLS_L2_PUSH   = 3'd4,
    CLS_COPYBACK  = 3'd5
  } cls_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GNT  = 2'd1,
    PH_ACK  = 2'd2,
    PH_WIN  = 2'd3
  } phase_e;

  // reserved codes rank with plain requests
  function automatic logic [CLS_W-1:0] cls_rank(input logic [CLS_W-1:0] c);
    return (c > CLS_COPYBACK) ? CLS_PLAIN : c;
  endfunction
endpackage

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 3,
  parameter int CPU_W   = 2
) (
  input  logic [NUM_CPU-1:0]       cpu_req_i,
  input  logic [NUM_CPU*CLS_W-1:0] cpu_cls_i,
  input  logic                     l2_req_i,
  input  logic [CLS_W-1:0]         l2_cls_i,
  input  logic                     int_req_i,
  input  logic [CLS_W-1:0]         int_cls_i,
  input  logic [CPU_W-1:0]         ptr_i,
  input  logic                     force_vld_i,
  input  logic [CPU_W-1:0]         force_idx_i,
  output logic                     win_vld_o,
  output logic [IDX_W-1:0]         win_idx_o
);
  localparam logic [IDX_W-1:0] L2_IDX  = IDX_W'(NUM_CPU);
  localparam logic [IDX_W-1:0] INT_IDX = IDX_W'(NUM_CPU + 1);

  logic [CLS_W-1:0] cpu_rank [NUM_CPU];

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_rank
    assign cpu_rank[g] = cls_rank(cpu_cls_i[g*CLS_W +: CLS_W]);
  end

  logic             best_vld;
  logic [CLS_W-1:0] best_rank;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    best_vld  = 1'b0;
    best_rank = '0;
    best_idx  = '0;
    // scan order gives tie precedence: internal, L2, processors from ptr
    if (int_req_i) begin
      best_vld  = 1'b1;
      best_rank = cls_rank(int_cls_i);
      best_idx  = INT_IDX;
    end
    if (l2_req_i && (!best_vld || cls_rank(l2_cls_i) > best_rank)) begin
      best_vld  = 1'b1;
      best_rank = cls_rank(l2_cls_i);
      best_idx  = L2_IDX;
    end
    for (int k = 0; k < NUM_CPU; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= NUM_CPU) j = j - NUM_CPU;
      if (cpu_req_i[j] && (!best_vld || cpu_rank[j] > best_rank)) begin
        best_vld  = 1'b1;
        best_rank = cpu_rank[j];
        best_idx  = IDX_W'(j);
      end
    end
    if (force_vld_i) begin
      best_vld = 1'b1;
      best_idx = IDX_W'(force_idx_i);
    end
  end

  assign win_vld_o = best_vld;
  assign win_idx_o = best_idx;
endmodule

// File: rtl/arb_rotate.sv
module arb_rotate #(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_fire_i,
  input  logic [CPU_W-1:0] cpu_idx_i,
  output logic [CPU_W-1:0] ptr_o,
  output logic [CPU_W-1:0] last_o
);
  localparam logic [CPU_W-1:0] TOP_IDX = CPU_W'(NUM_CPU - 1);

  logic [CPU_W-1:0] ptr_q, last_q, ptr_d;

  assign ptr_d = (cpu_idx_i == TOP_IDX) ? '0 : cpu_idx_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      last_q <= '0;
    end else if (cpu_fire_i) begin
      ptr_q  <= ptr_d;
      last_q <= cpu_idx_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign last_o = last_q;
endmodule

// File: rtl/arb_tenure_track.sv
module arb_tenure_track #(
  parameter int NUM_CPU  = 4,
  parameter int MAX_PEND = 2,
  parameter int IDX_W    = 3,
  parameter int CPU_W    = 2,
  parameter int OCC_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_fire_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  input  logic             grant_snoop_i,
  input  logic             ack_cycle_i,
  input  logic             win_cycle_i,
  input  logic             artry_i,
  input  logic             data_done_i,
  output logic             slot_free_o,
  output logic [OCC_W-1:0] occ_o,
  output logic             rb_ready_o,
  output logic [CPU_W-1:0] rb_owner_o
);
  localparam logic [IDX_W-1:0] INT_IDX = IDX_W'(NUM_CPU + 1);
  localparam logic [IDX_W-1:0] CPU_LIM = IDX_W'(NUM_CPU);

  logic [IDX_W-1:0] src_q;
  logic             snoop_q;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [OCC_W+1:0] occ_up, occ_dn;
  logic             rb_pend_q, rb_ready_q;
  logic [CPU_W-1:0] rb_owner_q;
  logic             retry_any, retry_cpu, snoop_done;

  assign retry_any  = win_cycle_i && artry_i;
  assign retry_cpu  = retry_any && (src_q < CPU_LIM);
  assign snoop_done = ack_cycle_i && (src_q == INT_IDX) && snoop_q && rb_pend_q;

  always_comb begin
    occ_up = {2'b00, occ_q} + {{(OCC_W+1){1'b0}}, grant_fire_i};
    occ_dn = {{(OCC_W+1){1'b0}}, data_done_i} + {{(OCC_W+1){1'b0}}, retry_any};
    occ_d  = (occ_dn >= occ_up) ? '0 : OCC_W'(occ_up - occ_dn);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      snoop_q <= 1'b0;
      occ_q   <= '0;
    end else begin
      occ_q <= occ_d;
      if (grant_fire_i) begin
        src_q   <= grant_idx_i;
        snoop_q <= grant_snoop_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_pend_q  <= 1'b0;
      rb_ready_q <= 1'b0;
      rb_owner_q <= '0;
    end else begin
      if (retry_cpu) begin
        rb_pend_q  <= 1'b1;
        rb_owner_q <= CPU_W'(src_q);
      end else if (snoop_done) begin
        rb_pend_q <= 1'b0;
      end
      if (snoop_done)        rb_ready_q <= 1'b1;
      else if (grant_fire_i) rb_ready_q <= 1'b0;
    end
  end

  assign slot_free_o = occ_q < OCC_W'(MAX_PEND);
  assign occ_o       = occ_q;
  assign rb_ready_o  = rb_ready_q;
  assign rb_owner_o  = rb_owner_q;
endmodule

// File: rtl/addr_bus_arbiter.sv
module addr_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int MAX_PEND = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     park_en_i,
  input  logic [NUM_CPU-1:0]       cpu_req_i,
  input  logic [NUM_CPU*CLS_W-1:0] cpu_cls_i,
  input  logic                     l2_req_i,
  input  logic [CLS_W-1:0]         l2_cls_i,
  input  logic                     int_req_i,
  input  logic [CLS_W-1:0]         int_cls_i,
  input  logic                     artry_i,
  input  logic                     data_done_i,
  output logic [NUM_CPU-1:0]       cpu_gnt_o,
  output logic                     l2_gnt_o,
  output logic                     int_gnt_o,
  output logic                     aack_o
);
  localparam int NREQ  = NUM_CPU + 2;
  localparam int IDX_W = $clog2(NREQ);
  localparam int CPU_W = $clog2(NUM_CPU);
  localparam int OCC_W = $clog2(MAX_PEND + 1);
  localparam logic [IDX_W-1:0] INT_IDX = IDX_W'(NUM_CPU + 1);
  localparam logic [IDX_W-1:0] CPU_LIM = IDX_W'(NUM_CPU);

  phase_e            phase_q, phase_d;
  logic [NREQ-1:0]   gnt_q, gnt_d;
  logic [CPU_W-1:0]  ptr, last_cpu, rb_owner;
  logic [OCC_W-1:0]  occ;
  logic              slot_free, rb_ready, force_vld;
  logic              win_vld, decide, any_req, grant_fire, grant_snoop, cpu_fire;
  logic [IDX_W-1:0]  win_idx;

  assign any_req     = (|cpu_req_i) || l2_req_i || int_req_i;
  assign decide      = (phase_q == PH_IDLE) || (phase_q == PH_WIN);
  assign force_vld   = rb_ready && cpu_req_i[rb_owner];
  assign grant_fire  = decide && slot_free && win_vld;
  assign grant_snoop = (win_idx == INT_IDX) && (int_cls_i == CLS_SNOOP);
  assign cpu_fire    = grant_fire && (win_idx < CPU_LIM);

  arb_select #(
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W),
    .CPU_W   (CPU_W)
  ) i_select (
    .cpu_req_i   (cpu_req_i),
    .cpu_cls_i   (cpu_cls_i),
    .l2_req_i    (l2_req_i),
    .l2_cls_i    (l2_cls_i),
    .int_req_i   (int_req_i),
    .int_cls_i   (int_cls_i),
    .ptr_i       (ptr),
    .force_vld_i (force_vld),
    .force_idx_i (rb_owner),
    .win_vld_o   (win_vld),
    .win_idx_o   (win_idx)
  );

  arb_rotate #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
  ) i_rotate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_fire_i (cpu_fire),
    .cpu_idx_i  (CPU_W'(win_idx)),
    .ptr_o      (ptr),
    .last_o     (last_cpu)
  );

  arb_tenure_track #(
    .NUM_CPU  (NUM_CPU),
    .MAX_PEND (MAX_PEND),
    .IDX_W    (IDX_W),
    .CPU_W    (CPU_W),
    .OCC_W    (OCC_W)
  ) i_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .grant_fire_i  (grant_fire),
    .grant_idx_i   (win_idx),
    .grant_snoop_i (grant_snoop),
    .ack_cycle_i   (phase_q == PH_ACK),
    .win_cycle_i   (phase_q == PH_WIN),
    .artry_i       (artry_i),
    .data_done_i   (data_done_i),
    .slot_free_o   (slot_free),
    .occ_o         (occ),
    .rb_ready_o    (rb_ready),
    .rb_owner_o    (rb_owner)
  );

  always_comb begin
    gnt_d   = '0;
    phase_d = PH_IDLE;
    unique case (phase_q)
      PH_GNT: phase_d = PH_ACK;
      PH_ACK: phase_d = PH_WIN;
      default: begin
        if (grant_fire) begin
          gnt_d[win_idx] = 1'b1;
          phase_d        = PH_GNT;
        end else if (!any_req && park_en_i) begin
          gnt_d[last_cpu] = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      gnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      gnt_q   <= gnt_d;
    end
  end

  assign cpu_gnt_o = gnt_q[NUM_CPU-1:0];
  assign l2_gnt_o  = gnt_q[NUM_CPU];
  assign int_gnt_o = gnt_q[NUM_CPU+1];
  assign aack_o    = (phase_q == PH_ACK);
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int MAX_PEND = 2,
  parameter int CPU_W    = 2,
  parameter int OCC_W    = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               park_en_i,
  input logic               any_req,
  input logic               decide,
  input logic [1:0]         phase,
  input logic [OCC_W-1:0]   occ,
  input logic               slot_free,
  input logic               rb_ready,
  input logic [CPU_W-1:0]   rb_owner,
  input logic [NUM_CPU-1:0] cpu_req_i,
  input logic [NUM_CPU-1:0] cpu_gnt_o,
  input logic               l2_gnt_o,
  input logic               int_gnt_o,
  input logic               aack_o
);
  logic [NUM_CPU+1:0] all_gnt;
  assign all_gnt = {int_gnt_o, l2_gnt_o, cpu_gnt_o};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (all_gnt == '0 && !aack_o && occ == '0);
    end
  end

  assert_gnt_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(all_gnt));

  assert_int_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_gnt_o |-> (cpu_gnt_o == '0 && !l2_gnt_o));

  assert_gnt_then_aack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GNT) |=> (aack_o && all_gnt == '0));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OCC_W'(MAX_PEND));

  assert_hold_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && !slot_free) |=> (phase != PH_GNT));

  assert_grant_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && slot_free && rb_ready && cpu_req_i[rb_owner]) |=> cpu_gnt_o[$past(rb_owner)]);

  assert_park_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && !any_req && park_en_i) |=> ($countones(cpu_gnt_o) == 1 && !aack_o));

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && !any_req && !park_en_i) |=> (all_gnt == '0));
endmodule

bind addr_bus_arbiter arb_checker #(
  .NUM_CPU  (NUM_CPU),
  .MAX_PEND (MAX_PEND),
  .CPU_W    (CPU_W),
  .OCC_W    (OCC_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .park_en_i (park_en_i),
  .any_req   (any_req),
  .decide    (decide),
  .phase     (phase_q),
  .occ       (occ),
  .slot_free (slot_free),
  .rb_ready  (rb_ready),
  .rb_owner  (rb_owner),
  .cpu_req_i (cpu_req_i),
  .cpu_gnt_o (cpu_gnt_o),
  .l2_gnt_o  (l2_gnt_o),
  .int_gnt_o (int_gnt_o),
  .aack_o    (aack_o)
);

// File: tb/test_addr_bus_arbiter.sv
module test_addr_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int MAXP = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           park_en = 1'b0;
  logic [N-1:0]   cpu_req = '0;
  logic [3*N-1:0] cpu_cls = '0;
  logic           l2_req = 1'b0, int_req = 1'b0;
  logic [2:0]     l2_cls = '0, int_cls = '0;
  logic           artry = 1'b0, data_done = 1'b0;
  logic [N-1:0]   cpu_gnt;
  logic           l2_gnt, int_gnt, aack;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit retry_mode = 0, auto_done = 1, rnd_artry = 0;

  // reference model state
  int m_phase, m_occ, m_ptr, m_last, m_src, m_rown;
  bit m_snoop, m_rpend, m_rready, m_aack;
  bit [N+1:0] m_gnt;
  string m_reason;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bus_arbiter #(.NUM_CPU(N), .MAX_PEND(MAXP)) i_addr_bus_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .park_en_i(park_en),
    .cpu_req_i(cpu_req), .cpu_cls_i(cpu_cls),
    .l2_req_i(l2_req), .l2_cls_i(l2_cls),
    .int_req_i(int_req), .int_cls_i(int_cls),
    .artry_i(artry), .data_done_i(data_done),
    .cpu_gnt_o(cpu_gnt), .l2_gnt_o(l2_gnt), .int_gnt_o(int_gnt), .aack_o(aack)
  );

  function automatic int rk(input logic [2:0] c);
    return (c > 3'd5) ? 0 : int'(c);
  endfunction

  task automatic model_reset();
    m_phase = 0; m_occ = 0; m_ptr = 0; m_last = 0; m_src = 0; m_rown = 0;
    m_snoop = 0; m_rpend = 0; m_rready = 0; m_aack = 0; m_gnt = '0;
    m_reason = "R1";
  endtask

  task automatic model_step();
    int ph, dec, win, best;
    bit any;
    ph  = m_phase;
    dec = (data_done ? 1 : 0) + ((ph == 3 && artry) ? 1 : 0);
    if (ph == 3 && artry && m_src < N) begin m_rpend = 1; m_rown = m_src; end
    if (ph == 2 && m_src == N+1 && m_snoop && m_rpend) begin m_rready = 1; m_rpend = 0; end
    m_gnt = '0; m_aack = 0;
    if (ph == 1) begin m_phase = 2; m_aack = 1; m_reason = "R6"; end
    else if (ph == 2) begin m_phase = 3; m_reason = "R6"; end
    else begin
      m_phase = 0;
      any = (cpu_req != 0) || l2_req || int_req;
      win = -1;
      if (m_occ < MAXP) begin
        if (m_rready && cpu_req[m_rown]) begin win = m_rown; m_reason = "R8"; end
        else begin
          best = -1;
          if (int_req) begin win = N+1; best = rk(int_cls); end
          if (l2_req && rk(l2_cls) > best) begin win = N; best = rk(l2_cls); end
          for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (cpu_req[j] && rk(cpu_cls[j*3 +: 3]) > best) begin
              win = j; best = rk(cpu_cls[j*3 +: 3]);
            end
          end
          if (win == N+1) m_reason = "R3";
          else if (win == N) m_reason = "R2";
          else if (win >= 0) m_reason = (best == 5) ? "R5" : "R4";
        end
      end
      if (win >= 0) begin
        m_gnt[win] = 1'b1; m_phase = 1; m_src = win;
        m_snoop = (win == N+1) && (int_cls == 3'd2);
        m_rready = 0;
        m_occ = m_occ + 1;
        if (win < N) begin m_ptr = (win + 1) % N; m_last = win; end
      end else if (!any && park_en) begin
        m_gnt[m_last] = 1'b1; m_reason = "R9";
      end else begin
        m_reason = any ? "R7" : "R10";
      end
    end
    m_occ = m_occ - dec;
    if (m_occ < 0) m_occ = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [N+2:0] act, exp;
      act = {aack, int_gnt, l2_gnt, cpu_gnt};
      exp = {m_aack, m_gnt};
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s t=%0t actual=%b expected=%b", m_reason, $time, act, exp);
      end
    end
  end

  task automatic set_cls(input int i, input logic [2:0] c);
    cpu_cls[i*3 +: 3] = c;
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #1;
      artry = 1'b0;
      if (retry_mode && m_phase == 3 && m_src < N) begin
        artry = 1'b1; retry_mode = 0; cpu_req = '0;
      end else if (rnd_artry && m_phase == 3) begin
        artry = ($urandom % 4) == 0;
      end
      data_done = auto_done && m_occ > 0 && ($urandom % 3) == 0;
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    n_cmp++;
    if ({aack, int_gnt, l2_gnt, cpu_gnt} !== '0) begin
      n_bad++;
      $display("FAIL R1 actual=%b expected=0", {aack, int_gnt, l2_gnt, cpu_gnt});
    end
    #1 rst_n = 1'b1;
    run(4);                                   // R10: idle, parking off
    cpu_req = 4'b0111; run(30);               // R4: rotation among plain requests
    cpu_req = 4'b1111; set_cls(3, 3'd5); run(20);  // R5: copy-back overrides rotation
    set_cls(3, 3'd0);
    l2_req = 1; l2_cls = 3'd4; int_req = 1; int_cls = 3'd3; run(12); // R2
    l2_cls = 3'd2; int_cls = 3'd2; run(12);   // R3: tie goes to internal
    l2_cls = 3'd7; int_cls = 3'd6; run(12);   // R2: reserved codes rank as plain
    l2_req = 0; int_req = 0;
    auto_done = 0; run(20);                   // R7: stall at the pending limit
    auto_done = 1; run(10);
    cpu_req = 4'b0010; retry_mode = 1; run(8); // R8: retry processor 1
    cpu_req = 4'b0110; int_req = 1; int_cls = 3'd2; run(6);
    int_req = 0; run(20);                     // grant-back to processor 1
    cpu_req = '0; park_en = 1; run(12);       // R9: park on last master
    cpu_req = 4'b0100; run(6);
    cpu_req = '0; run(6);
    park_en = 0; run(6);                      // R10
    rnd_artry = 1;
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk); #2;
      cpu_req = N'($urandom);
      cpu_cls = (3*N)'($urandom);
      l2_req  = ($urandom % 3) == 0; l2_cls = 3'($urandom);
      int_req = ($urandom % 4) == 0; int_cls = 3'($urandom);
      if (($urandom % 5) == 0) cpu_req = '0;
      if ((it % 200) == 0) park_en = ~park_en;
      if (($urandom % 50) == 0) begin l2_req = 0; int_req = 0; cpu_req = '0; end
      run(1);
    end
    cpu_req = '0; l2_req = 0; int_req = 0; run(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule